// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the multi-cycle sequence a 16-bit processor needs when it takes an interrupt or exception, and when it executes the return-from-interrupt instruction. It owns the status word (privilege bit, running priority, condition flags), the stack register R6, and the two banked stack pointers for the supervisor and user stacks. The core presents an instruction boundary and the incremented PC. The block then talks to word memory through a request/ready handshake and hands back a new PC.

On entry, a request is accepted only if it is enabled and its priority is strictly higher than the running priority. The block enters supervisor mode and swaps R6 onto the supervisor stack if needed. It pushes the old status word and then the PC, and it fetches the handler address from a vector table based at x0100. External sources use entries from x0180 upward; exceptions use entries below x0180. On return, the block pops the PC and then the status word, and it re-banks R6 for the restored privilege. If the return is attempted in user mode, it starts a privilege exception instead. While it works, `busy` holds instruction fetch off.

Top module: `irq_seq`

## Requirements
- R1: After reset, `busy`, `done` and `memReq` are 0, `psrOut` equals the reset status word (default x8002: user mode, priority 0, zero flag set), and `r6Out` equals the reset user stack value (default x5000).
- R2: A request is ignored unless, in the same cycle, `boundary`, `reqValid` and `reqEnable` are all 1 and `reqPri` is strictly greater than `psrOut[10:8]`. An ignored request leaves `busy` at 0 and `psrOut` unchanged.
- R3: On entry, `psrOut[15]` (1 = user) becomes 0 and `psrOut[10:8]` takes the accepted priority, while `psrOut[2:0]` is kept. If the block was in user mode, R6 is saved as the user pointer and reloaded from the supervisor pointer (default reset value x3000). In supervisor mode, R6 is left as it is.
- R4: The entry pushes the old status word to word address R6−2 and then the saved PC to R6−4, with bit 0 of R6 cleared. It finishes with R6 four below its starting value.
- R5: The handler address is read from x0100 plus the vector with its bit 0 cleared, so vector x80 reads x0180 and x85 reads x0184. The word read appears on `pcOut` in the cycle `done` pulses.
- R6: A return in supervisor mode reads the PC from word R6, then the status word from R6+2, and leaves R6 four higher.
- R7: If the restored `psrOut[15]` is 1, the post-pop R6 is saved as the supervisor pointer and R6 is reloaded from the user pointer. If it is 0, R6 keeps the post-pop value.
- R8: A return requested in user mode starts an entry with the exception vector (default x02, table word x0102) and keeps the priority unchanged. The pushed status word is the user-mode one.
- R9: `busy` is 1 from the cycle after acceptance until `done` pulses. A memory request holds its address, and R6 does not change, until `memReady` is 1.
- R10: If a return and an acceptable request arrive at the same boundary, the return runs and the request is not taken in that cycle.
- R11: A higher-priority request accepted during a handler nests its frame directly below the first frame, and the two returns unwind both frames in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Current instruction completes this cycle |
| retValid | input | 1 | The instruction at this boundary is the return-from-interrupt |
| reqValid | input | 1 | Device request pending |
| reqEnable | input | 1 | Device interrupt enable |
| reqPri | input | 3 | Device request priority |
| reqVec | input | 8 | Device vector |
| pcIn | input | 16 | Incremented PC of the running program |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Transaction complete |
| busy | output | 1 | Sequence in progress, fetch stalled |
| done | output | 1 | One-cycle pulse: sequence finished, pcOut valid |
| pcOut | output | 16 | New PC |
| psrOut | output | 16 | Current status word |
| r6Out | output | 16 | Current stack register |

## Verification
A return instruction and an acceptable device request can arrive at the same instruction boundary. The bench drives both in one cycle while the block is in a handler, at a request priority above the handler's own. It expects the return to complete first and restore the user-mode state. With the request still held, the next boundary must then take the request from user mode. Both outcomes are judged from the PC, the status word, R6 and the stack words in memory, for example the supervisor pointer reloaded to x3000 on the second entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int WORD_W = 16;
  localparam int PRI_W  = 3;
  localparam int VEC_W  = 8;

  typedef enum logic [1:0] {
    ADDR_PUSH  = 2'd0,
    ADDR_POP   = 2'd1,
    ADDR_TABLE = 2'd2
  } addr_sel_e;

  typedef struct packed {
    logic      enterLoad;
    logic      useExc;
    logic      pushStep;
    logic      popStep;
    logic      ldPc;
    logic      ldPsr;
    logic      finish;
    logic      wdSelPc;
    addr_sel_e addrSel;
  } ctl_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             retValid,
  input  logic             reqValid,
  input  logic             reqEnable,
  input  logic [PRI_W-1:0] reqPri,
  input  logic [PRI_W-1:0] curPri,
  input  logic             curUser,
  input  logic             memReady,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output ctl_t             ctl
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_PSR, ST_WR_PC, ST_RD_VEC, ST_RD_PC, ST_RD_PSR
  } state_e;

  state_e state, stateNext;
  logic reqOk;

  assign reqOk = boundary && reqValid && reqEnable && (reqPri > curPri);
  assign busy  = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (boundary && retValid) begin
          if (curUser) begin
            ctl.enterLoad = 1'b1;
            ctl.useExc    = 1'b1;
            stateNext     = ST_WR_PSR;
          end else begin
            stateNext = ST_RD_PC;
          end
        end else if (reqOk) begin
          ctl.enterLoad = 1'b1;
          stateNext     = ST_WR_PSR;
        end
      end
      ST_WR_PSR, ST_WR_PC: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = ADDR_PUSH;
        ctl.wdSelPc = (state == ST_WR_PC);
        if (memReady) begin
          ctl.pushStep = 1'b1;
          stateNext    = (state == ST_WR_PSR) ? ST_WR_PC : ST_RD_VEC;
        end
      end
      ST_RD_VEC: begin
        memReq      = 1'b1;
        ctl.addrSel = ADDR_TABLE;
        if (memReady) begin
          ctl.ldPc   = 1'b1;
          ctl.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_RD_PC: begin
        memReq      = 1'b1;
        ctl.addrSel = ADDR_POP;
        if (memReady) begin
          ctl.ldPc    = 1'b1;
          ctl.popStep = 1'b1;
          stateNext   = ST_RD_PSR;
        end
      end
      ST_RD_PSR: begin
        memReq      = 1'b1;
        ctl.addrSel = ADDR_POP;
        if (memReady) begin
          ctl.ldPsr  = 1'b1;
          ctl.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R9
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_PSR    = 16'h8002,
  parameter logic [WORD_W-1:0] RST_R6     = 16'h5000,
  parameter logic [WORD_W-1:0] RST_SSP    = 16'h3000,
  parameter logic [WORD_W-1:0] TABLE_BASE = 16'h0100,
  parameter logic [VEC_W-1:0]  EXC_VEC    = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [PRI_W-1:0]  reqPri,
  input  logic [VEC_W-1:0]  reqVec,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReq,
  input  logic              memReady,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] psrQ,
  output logic [WORD_W-1:0] r6Q,
  output logic [WORD_W-1:0] pcQ,
  output logic              doneQ
);
  localparam int PRI_LO = 8;
  localparam int PRI_HI = PRI_LO + PRI_W - 1;
  localparam int USR_B  = WORD_W - 1;

  logic [WORD_W-1:0] sspQ, uspQ, savedPsr, savedPc;
  logic [VEC_W-1:0]  vecQ;
  logic [WORD_W-1:0] r6Al, r6Dn, r6Up, psrEnter;
  logic [PRI_W-1:0]  priNew;

  assign r6Al   = {r6Q[WORD_W-1:1], 1'b0};
  assign r6Dn   = r6Al - WORD_W'(2);
  assign r6Up   = r6Al + WORD_W'(2);
  assign priNew = ctl.useExc ? psrQ[PRI_HI:PRI_LO] : reqPri;

  always_comb begin
    psrEnter                = psrQ;
    psrEnter[USR_B]         = 1'b0;
    psrEnter[PRI_HI:PRI_LO] = priNew;
  end

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_PUSH:  memAddr = r6Dn;
      ADDR_POP:   memAddr = r6Al;
      default:    memAddr = TABLE_BASE + {{(WORD_W-VEC_W){1'b0}}, vecQ[VEC_W-1:1], 1'b0};
    endcase
  end

  assign memWdata = ctl.wdSelPc ? savedPc : savedPsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psrQ     <= RST_PSR;
      r6Q      <= RST_R6;
      sspQ     <= RST_SSP;
      uspQ     <= RST_R6;
      savedPsr <= '0;
      savedPc  <= '0;
      vecQ     <= '0;
      pcQ      <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.enterLoad) begin
        savedPsr <= psrQ;
        savedPc  <= pcIn;
        vecQ     <= ctl.useExc ? EXC_VEC : reqVec;
        psrQ     <= psrEnter;
        if (psrQ[USR_B]) begin
          uspQ <= r6Q;
          r6Q  <= sspQ;
        end
      end
      if (ctl.pushStep) r6Q <= r6Dn;
      if (ctl.popStep)  r6Q <= r6Up;
      if (ctl.ldPc)     pcQ <= memRdata;
      if (ctl.ldPsr) begin
        psrQ <= memRdata;
        if (memRdata[USR_B]) begin
          sspQ <= r6Up;
          r6Q  <= uspQ;
        end else begin
          r6Q <= r6Up;
        end
      end
    end
  end

  AST_R6_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(r6Q)); // R9
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] RST_PSR    = 16'h8002,
  parameter logic [15:0] RST_R6     = 16'h5000,
  parameter logic [15:0] RST_SSP    = 16'h3000,
  parameter logic [15:0] TABLE_BASE = 16'h0100,
  parameter logic [7:0]  EXC_VEC    = 8'h02
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        retValid,
  input  logic        reqValid,
  input  logic        reqEnable,
  input  logic [2:0]  reqPri,
  input  logic [7:0]  reqVec,
  input  logic [15:0] pcIn,
  output logic        memReq,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata,
  input  logic        memReady,
  output logic        busy,
  output logic        done,
  output logic [15:0] pcOut,
  output logic [15:0] psrOut,
  output logic [15:0] r6Out
);
  ctl_t ctl;

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .retValid(retValid),
    .reqValid(reqValid), .reqEnable(reqEnable), .reqPri(reqPri),
    .curPri(psrOut[10:8]), .curUser(psrOut[15]), .memReady(memReady),
    .memReq(memReq), .memWe(memWe), .busy(busy), .ctl(ctl)
  );

  irq_seq_dp #(
    .RST_PSR(RST_PSR), .RST_R6(RST_R6), .RST_SSP(RST_SSP),
    .TABLE_BASE(TABLE_BASE), .EXC_VEC(EXC_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqPri(reqPri), .reqVec(reqVec),
    .pcIn(pcIn), .memRdata(memRdata), .memReq(memReq), .memReady(memReady),
    .memAddr(memAddr), .memWdata(memWdata), .psrQ(psrOut), .r6Q(r6Out),
    .pcQ(pcOut), .doneQ(done)
  );

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr)); // R9
  AST_PUSH_SUPER: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !psrOut[15]); // R3
  AST_STACK_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memAddr[0]); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
endmodule

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boundary = 1'b0, retValid = 1'b0, reqValid = 1'b0, reqEnable = 1'b0;
  logic [2:0]  reqPri = '0;
  logic [7:0]  reqVec = '0;
  logic [15:0] pcIn = '0;
  logic        memReq, memWe, busy, done;
  logic [15:0] memAddr, memWdata, pcOut, psrOut, r6Out;
  logic [15:0] memRdata = '0;
  logic        memReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  logic [15:0] mem [logic [15:0]];

  always #2 clk = ~clk;

  irq_seq u_irq_seq (
    .clk(clk), .rstN(rstN), .boundary(boundary), .retValid(retValid),
    .reqValid(reqValid), .reqEnable(reqEnable), .reqPri(reqPri), .reqVec(reqVec),
    .pcIn(pcIn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .pcOut(pcOut), .psrOut(psrOut), .r6Out(r6Out)
  );

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    memReady <= 1'b0;
    if (memReq && !memReady) begin
      if (cnt >= lat) begin
        cnt <= 0;
        memReady <= 1'b1;
        if (memWe) mem[memAddr] = memWdata;
        else memRdata <= rd(memAddr);
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, {15'd0, done}, 16'h1);
  endtask

  task automatic t_reset();
    chk("R1 busy", {15'd0, busy}, 16'h0);
    chk("R1 done", {15'd0, done}, 16'h0);
    chk("R1 memReq", {15'd0, memReq}, 16'h0);
    chk("R1 psr", psrOut, 16'h8002);
    chk("R1 r6", r6Out, 16'h5000);
  endtask

  task automatic t_reject();
    reqValid = 1'b1; reqEnable = 1'b1; reqPri = 3'd0; reqVec = 8'h80;
    pulse_boundary();                       // equal priority
    reqEnable = 1'b0; reqPri = 3'd5;
    pulse_boundary();                       // disabled
    reqEnable = 1'b1;
    repeat (3) @(negedge clk);              // no boundary
    reqValid = 1'b0;
    chk("R2 busy after rejects", {15'd0, busy}, 16'h0);
    chk("R2 psr unchanged", psrOut, 16'h8002);
  endtask

  task automatic t_entry();
    lat = 3;
    pcIn = 16'h3456; reqValid = 1'b1; reqEnable = 1'b1; reqPri = 3'd4; reqVec = 8'h80;
    pulse_boundary();
    reqValid = 1'b0;
    chk("R9 busy while waiting", {15'd0, busy}, 16'h1);
    chk("R9 no done while waiting", {15'd0, done}, 16'h0);
    wait_done("R5 entry");
    chk("R3 psr entry", psrOut, 16'h0402);
    chk("R3 r6 from ssp", r6Out, 16'h2FFC);
    chk("R4 pushed psr", rd(16'h2FFE), 16'h8002);
    chk("R4 pushed pc", rd(16'h2FFC), 16'h3456);
    chk("R5 handler x0180", pcOut, 16'h1200);
    lat = 0;
  endtask

  task automatic t_nested();
    pcIn = 16'h1210; reqValid = 1'b1; reqEnable = 1'b1; reqPri = 3'd3;
    pulse_boundary();
    chk("R2 lower pri ignored", {15'd0, busy}, 16'h0);
    reqPri = 3'd6; reqVec = 8'h85;
    pulse_boundary();
    reqValid = 1'b0;
    wait_done("R11 nested");
    chk("R11 psr", psrOut, 16'h0602);
    chk("R11 r6 no swap", r6Out, 16'h2FF8);
    chk("R11 pushed psr", rd(16'h2FFA), 16'h0402);
    chk("R11 pushed pc", rd(16'h2FF8), 16'h1210);
    chk("R5 odd vector to x0184", pcOut, 16'h1300);
    retValid = 1'b1;
    pulse_boundary();
    retValid = 1'b0;
    wait_done("R6 inner return");
    chk("R6 pc popped", pcOut, 16'h1210);
    chk("R6 psr popped", psrOut, 16'h0402);
    chk("R7 r6 stays super", r6Out, 16'h2FFC);
  endtask

  task automatic t_collide();
    pcIn = 16'h3458; reqValid = 1'b1; reqEnable = 1'b1; reqPri = 3'd7; reqVec = 8'h82;
    retValid = 1'b1;
    pulse_boundary();
    retValid = 1'b0;
    wait_done("R10 return first");
    chk("R10 pc from stack", pcOut, 16'h3456);
    chk("R10 psr user", psrOut, 16'h8002);
    chk("R7 r6 from usp", r6Out, 16'h5000);
    pulse_boundary();
    reqValid = 1'b0;
    wait_done("R10 request later");
    chk("R10 psr", psrOut, 16'h0702);
    chk("R7 ssp saved x3000", r6Out, 16'h2FFC);
    chk("R10 handler x0182", pcOut, 16'h1250);
    retValid = 1'b1;
    pulse_boundary();
    retValid = 1'b0;
    wait_done("R6 return to user");
    chk("R6 pc", pcOut, 16'h3458);
    chk("R7 r6 user", r6Out, 16'h5000);
  endtask

  task automatic t_priv();
    pcIn = 16'h3460; retValid = 1'b1;
    pulse_boundary();
    retValid = 1'b0;
    wait_done("R8 exception");
    chk("R8 psr pri kept", psrOut, 16'h0002);
    chk("R8 r6", r6Out, 16'h2FFC);
    chk("R8 pushed psr", rd(16'h2FFE), 16'h8002);
    chk("R8 pushed pc", rd(16'h2FFC), 16'h3460);
    chk("R8 handler x0102", pcOut, 16'h1400);
  endtask

  initial begin
    mem[16'h0180] = 16'h1200;
    mem[16'h0184] = 16'h1300;
    mem[16'h0182] = 16'h1250;
    mem[16'h0102] = 16'h1400;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_entry();
    t_nested();
    t_collide();
    t_priv();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule